// File: doc/BRIEF.md
# Stream-to-Register FIFO Bridge

This block lets a processor exchange packetized stream traffic without a DMA engine. A 32-bit AXI4-Lite slave exposes a small register file. Behind it sit two 512-word FIFOs: one is filled by an AXI4-Stream input, and the other drains to an AXI4-Stream output. Software moves payload one word at a time through a single data address per direction. Packet boundaries are carried as byte lengths.

On the receive side, every word accepted from the input stream is buffered. When the word carrying TLAST arrives, a descriptor is queued in a small side queue. The descriptor holds the packet's byte count and its ID/DEST/USER sideband. Software polls the occupancy register, reads the length register (which consumes one descriptor and latches its sideband), and then reads the data address once per word.

On the transmit side, software writes words to the transmit data address and then writes a byte length. The length write launches the buffered words as one packet, with TLAST on the final word and the programmed sideband driven alongside. Four interrupt causes are collected in a write-one-to-clear status register and gated by an enable register onto one interrupt line. A reset register flushes the transmit path, the receive path, or the whole block.

Top module: `sfb_bridge`

## Requirements
- R1: Every AXI4-Lite write is answered with BVALID and BRESP=OKAY (0) on the cycle after the address and data are accepted. Every read returns RVALID with RRESP=OKAY on the cycle after the address is accepted.
- R2: After reset, the interrupt status register (0x00) reads 0, the transmit vacancy (0x08) reads 512, the receive occupancy (0x14) reads 0, `irq` is low, `tx_tvalid` is low and `rx_tready` is high.
- R3: Register 0x14 reports how many receive FIFO words are filled. `rx_tready` is low while all 512 words are filled.
- R4: Register 0x1C returns the byte length (words × 4) of the oldest complete received packet. A packet becomes visible there only once its TLAST word is accepted. Reading 0x1C consumes that packet's entry. The register reads 0 when no complete packet is waiting.
- R5: Each read of 0x18 pops one receive word, in arrival order. A read of 0x18 while the receive FIFO is empty returns 0, leaves the occupancy unchanged and sets the underrun status bit.
- R6: Register 0x08 reports the empty transmit FIFO slots. Each write to 0x0C pushes one word. A write while the FIFO is full is dropped and sets the overrun status bit.
- R7: A non-zero write to 0x10 launches ceil(value/4) buffered words as one packet on the transmit stream, with TLAST asserted only on the final word. A zero write launches nothing.
- R8: The sideband layout is ID in bits [3:0], DEST in bits [7:4] and USER in bits [15:8]. Writing 0x20 sets the transmit sideband; its value is latched at launch and driven on every word of that packet. When 0x1C is read, the consumed packet's sideband is latched into 0x24, as captured from its TLAST word.
- R9: The status register 0x00 holds four bits: bit 0 receive packet complete, bit 1 transmit packet complete, bit 2 receive underrun, bit 3 transmit overrun. Writing a 1 to a bit clears it, so writing all ones clears every pending bit.
- R10: Register 0x04 holds four enable bits. `irq` is high exactly when some status bit and its enable bit are both set.
- R11: A write to 0x28 flushes the transmit path (FIFO and any packet in progress) if bit 0 is set, and flushes the receive path (FIFO and length queue) if bit 1 is set. Bit 2 flushes both paths and also clears status, enable, and both sideband registers.
- R12: While `tx_tvalid` is high and `tx_tready` is low, `tx_tvalid`, `tx_tdata` and `tx_tlast` hold their values into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| s_axil_awaddr | input | 8 | Write byte address |
| s_axil_awvalid | input | 1 | Write address valid |
| s_axil_awready | output | 1 | Write address ready |
| s_axil_wdata | input | 32 | Write data |
| s_axil_wvalid | input | 1 | Write data valid |
| s_axil_wready | output | 1 | Write data ready |
| s_axil_bresp | output | 2 | Write response (always OKAY) |
| s_axil_bvalid | output | 1 | Write response valid |
| s_axil_bready | input | 1 | Write response ready |
| s_axil_araddr | input | 8 | Read byte address |
| s_axil_arvalid | input | 1 | Read address valid |
| s_axil_arready | output | 1 | Read address ready |
| s_axil_rdata | output | 32 | Read data |
| s_axil_rresp | output | 2 | Read response (always OKAY) |
| s_axil_rvalid | output | 1 | Read data valid |
| s_axil_rready | input | 1 | Read data ready |
| rx_tdata | input | 32 | Receive stream data |
| rx_tvalid | input | 1 | Receive stream valid |
| rx_tready | output | 1 | Receive stream ready |
| rx_tlast | input | 1 | Receive stream end of packet |
| rx_tid | input | 4 | Receive stream ID |
| rx_tdest | input | 4 | Receive stream destination |
| rx_tuser | input | 8 | Receive stream user bits |
| tx_tdata | output | 32 | Transmit stream data |
| tx_tvalid | output | 1 | Transmit stream valid |
| tx_tready | input | 1 | Transmit stream ready |
| tx_tlast | output | 1 | Transmit stream end of packet |
| tx_tid | output | 4 | Transmit stream ID |
| tx_tdest | output | 4 | Transmit stream destination |
| tx_tuser | output | 8 | Transmit stream user bits |
| irq | output | 1 | Interrupt line |

## Verification
A register write takes effect at the clock edge that accepts it, and BVALID shows on the following cycle. A read's data is captured at its accepting edge and presented with RVALID one cycle later. The bench therefore checks the write response and read data at the falling edge right after acceptance, and any dependent state is read with a later transaction.

A received word changes the occupancy at the edge that accepts it. The packet length is queued at the TLAST edge, and status bits and `irq` follow one edge after their causing event. The first transmit word is valid in the cycle after the length write is accepted. A scoreboard monitor compares each transmit beat at the falling edge before the handshake edge, and it checks the hold rule on stalled beats one cycle later.

// File: rtl/sfb_pkg.sv
package sfb_pkg;

    localparam int DATA_W  = 32;
    localparam int ADDR_W  = 8;
    localparam int LEN_W   = 16;
    localparam int FIFO_D  = 512;
    localparam int DESC_D  = 16;
    localparam int ID_W    = 4;
    localparam int DEST_W  = 4;
    localparam int USER_W  = 8;
    localparam int IRQ_N   = 4;

    localparam logic [ADDR_W-1:0] REG_IRQ_STAT = 8'h00;
    localparam logic [ADDR_W-1:0] REG_IRQ_EN   = 8'h04;
    localparam logic [ADDR_W-1:0] REG_TX_VAC   = 8'h08;
    localparam logic [ADDR_W-1:0] REG_TX_DATA  = 8'h0C;
    localparam logic [ADDR_W-1:0] REG_TX_LEN   = 8'h10;
    localparam logic [ADDR_W-1:0] REG_RX_OCC   = 8'h14;
    localparam logic [ADDR_W-1:0] REG_RX_DATA  = 8'h18;
    localparam logic [ADDR_W-1:0] REG_RX_LEN   = 8'h1C;
    localparam logic [ADDR_W-1:0] REG_TX_SIDE  = 8'h20;
    localparam logic [ADDR_W-1:0] REG_RX_SIDE  = 8'h24;
    localparam logic [ADDR_W-1:0] REG_RESET    = 8'h28;

    localparam int IRQ_RX_DONE  = 0;
    localparam int IRQ_TX_DONE  = 1;
    localparam int IRQ_RX_UNDER = 2;
    localparam int IRQ_TX_OVER  = 3;

    localparam int RST_TX  = 0;
    localparam int RST_RX  = 1;
    localparam int RST_ALL = 2;

    typedef struct packed {
        logic [USER_W-1:0] user;
        logic [DEST_W-1:0] dest;
        logic [ID_W-1:0]   id;
    } side_t;

    localparam int SIDE_W = $bits(side_t);

    typedef struct packed {
        logic [LEN_W-1:0] bytes;
        side_t            side;
    } rx_desc_t;

    localparam int DESC_W = $bits(rx_desc_t);

    function automatic logic [LEN_W-1:0] bytes_to_words(input logic [LEN_W-1:0] b);
        logic [LEN_W:0] t;
        t = {1'b0, b} + (LEN_W+1)'(3);
        return t[LEN_W:2];
    endfunction

endpackage

// File: rtl/sfb_fifo.sv
module sfb_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 512,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flush,
    input  logic          push,
    input  logic [W-1:0]  wdata,
    input  logic          pop,
    output logic [W-1:0]  rdata,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wptr, rptr;
    logic          do_push, do_pop;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign rdata   = mem[rptr];

    function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (do_push) mem[wptr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (do_push) wptr <= nxt(wptr);
            if (do_pop)  rptr <= nxt(rptr);
            case ({do_push, do_pop})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
        end
    end

    // R5: popping an empty FIFO leaves it empty
    assert_empty_pop_R5: assert property (@(posedge clk) disable iff (rst)
        (pop && empty && !push && !flush) |=> (count == '0));

    // R3: the count never passes the depth
    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
        (full && push && !pop) |=> full);

endmodule

// File: rtl/sfb_axil.sv
module sfb_axil #(
    parameter int AW = 8,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] awaddr,
    input  logic          awvalid,
    output logic          awready,
    input  logic [DW-1:0] wdata,
    input  logic          wvalid,
    output logic          wready,
    output logic [1:0]    bresp,
    output logic          bvalid,
    input  logic          bready,
    input  logic [AW-1:0] araddr,
    input  logic          arvalid,
    output logic          arready,
    output logic [DW-1:0] rdata,
    output logic [1:0]    rresp,
    output logic          rvalid,
    input  logic          rready,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic [DW-1:0] wr_data,
    output logic          rd_en,
    output logic [AW-1:0] rd_addr,
    input  logic [DW-1:0] rd_data
);
    assign wr_en   = awvalid && wvalid && !bvalid;
    assign awready = wr_en;
    assign wready  = wr_en;
    assign wr_addr = awaddr;
    assign wr_data = wdata;
    assign bresp   = 2'b00;

    assign rd_en   = arvalid && !rvalid;
    assign arready = rd_en;
    assign rd_addr = araddr;
    assign rresp   = 2'b00;

    always_ff @(posedge clk) begin
        if (rst) begin
            bvalid <= 1'b0;
            rvalid <= 1'b0;
            rdata  <= '0;
        end else begin
            if (wr_en)       bvalid <= 1'b1;
            else if (bready) bvalid <= 1'b0;
            if (rd_en) begin
                rvalid <= 1'b1;
                rdata  <= rd_data;
            end else if (rready) begin
                rvalid <= 1'b0;
            end
        end
    end

    assert_bresp_due_R1: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> bvalid);

    assert_rresp_due_R1: assert property (@(posedge clk) disable iff (rst)
        rd_en |=> rvalid);

    assert_b_hold_R1: assert property (@(posedge clk) disable iff (rst)
        (bvalid && !bready) |=> bvalid);

endmodule

// File: rtl/sfb_rx_path.sv
module sfb_rx_path
    import sfb_pkg::*;
#(
    parameter int DW     = DATA_W,
    parameter int DEPTH  = FIFO_D,
    parameter int NDESC  = DESC_D,
    parameter int CW     = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flush,
    input  logic [DW-1:0] s_tdata,
    input  logic          s_tvalid,
    input  logic          s_tlast,
    input  side_t         s_side,
    output logic          s_tready,
    input  logic          pop_data,
    input  logic          pop_desc,
    output logic [DW-1:0] head_data,
    output logic [CW-1:0] occ,
    output rx_desc_t      head_desc,
    output logic          desc_avail,
    output logic          done_evt,
    output logic          under_evt
);
    localparam int DCW = $clog2(NDESC + 1);

    logic             dfull, dempty, lfull, lempty, fire;
    logic [LEN_W-1:0] pkt_words;
    logic [DCW-1:0]   lcount;
    rx_desc_t         new_desc;

    assign s_tready   = !dfull && !lfull;
    assign fire       = s_tvalid && s_tready;
    assign done_evt   = fire && s_tlast;
    assign under_evt  = pop_data && dempty;
    assign desc_avail = !lempty;

    assign new_desc.bytes = LEN_W'((pkt_words + LEN_W'(1)) << 2);
    assign new_desc.side  = s_side;

    always_ff @(posedge clk) begin
        if (rst || flush)  pkt_words <= '0;
        else if (done_evt) pkt_words <= '0;
        else if (fire)     pkt_words <= pkt_words + LEN_W'(1);
    end

    sfb_fifo #(.W(DW), .DEPTH(DEPTH), .CW(CW)) u_data (
        .clk(clk), .rst(rst), .flush(flush),
        .push(fire), .wdata(s_tdata),
        .pop(pop_data), .rdata(head_data),
        .count(occ), .full(dfull), .empty(dempty)
    );

    sfb_fifo #(.W(DESC_W), .DEPTH(NDESC), .CW(DCW)) u_desc (
        .clk(clk), .rst(rst), .flush(flush),
        .push(done_evt), .wdata(new_desc),
        .pop(pop_desc), .rdata(head_desc),
        .count(lcount), .full(lfull), .empty(lempty)
    );

    // R3: input is refused while every slot is filled
    assert_ready_full_R3: assert property (@(posedge clk) disable iff (rst)
        (occ == CW'(DEPTH)) |-> !s_tready);

    // R4: a length entry appears only on a TLAST acceptance
    assert_len_on_last_R4: assert property (@(posedge clk) disable iff (rst)
        (!done_evt && !flush && lempty) |=> lempty);

endmodule

// File: rtl/sfb_tx_path.sv
module sfb_tx_path
    import sfb_pkg::*;
#(
    parameter int DW    = DATA_W,
    parameter int DEPTH = FIFO_D,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             push,
    input  logic [DW-1:0]    wdata,
    input  logic             launch,
    input  logic [LEN_W-1:0] launch_bytes,
    input  side_t            launch_side,
    output logic [CW-1:0]    vacancy,
    output logic [DW-1:0]    m_tdata,
    output logic             m_tvalid,
    input  logic             m_tready,
    output logic             m_tlast,
    output side_t            m_side,
    output logic             done_evt,
    output logic             over_evt
);
    logic             full, empty, fire, idle;
    logic [CW-1:0]    count;
    logic [LEN_W-1:0] remaining;

    assign idle     = (remaining == '0);
    assign m_tvalid = !idle && !empty;
    assign m_tlast  = (remaining == LEN_W'(1));
    assign fire     = m_tvalid && m_tready;
    assign done_evt = fire && m_tlast;
    assign over_evt = push && full;
    assign vacancy  = CW'(DEPTH) - count;

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            remaining <= '0;
            m_side    <= '0;
        end else if (idle && launch && launch_bytes != '0) begin
            remaining <= bytes_to_words(launch_bytes);
            m_side    <= launch_side;
        end else if (fire) begin
            remaining <= remaining - LEN_W'(1);
        end
    end

    sfb_fifo #(.W(DW), .DEPTH(DEPTH), .CW(CW)) u_data (
        .clk(clk), .rst(rst), .flush(flush),
        .push(push), .wdata(wdata),
        .pop(fire), .rdata(m_tdata),
        .count(count), .full(full), .empty(empty)
    );

    // R12: a stalled beat holds
    assert_stall_hold_R12: assert property (@(posedge clk) disable iff (rst)
        (m_tvalid && !m_tready && !flush) |=> (m_tvalid && $stable(m_tdata) && $stable(m_tlast)));

    // R7: the TLAST beat ends the packet
    assert_last_ends_R7: assert property (@(posedge clk) disable iff (rst)
        done_evt |=> !m_tvalid);

endmodule

// File: rtl/sfb_bridge.sv
module sfb_bridge
    import sfb_pkg::*;
#(
    parameter int DW    = DATA_W,
    parameter int AW    = ADDR_W,
    parameter int DEPTH = FIFO_D,
    parameter int NDESC = DESC_D
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [AW-1:0]     s_axil_awaddr,
    input  logic              s_axil_awvalid,
    output logic              s_axil_awready,
    input  logic [DW-1:0]     s_axil_wdata,
    input  logic              s_axil_wvalid,
    output logic              s_axil_wready,
    output logic [1:0]        s_axil_bresp,
    output logic              s_axil_bvalid,
    input  logic              s_axil_bready,
    input  logic [AW-1:0]     s_axil_araddr,
    input  logic              s_axil_arvalid,
    output logic              s_axil_arready,
    output logic [DW-1:0]     s_axil_rdata,
    output logic [1:0]        s_axil_rresp,
    output logic              s_axil_rvalid,
    input  logic              s_axil_rready,
    input  logic [DW-1:0]     rx_tdata,
    input  logic              rx_tvalid,
    output logic              rx_tready,
    input  logic              rx_tlast,
    input  logic [ID_W-1:0]   rx_tid,
    input  logic [DEST_W-1:0] rx_tdest,
    input  logic [USER_W-1:0] rx_tuser,
    output logic [DW-1:0]     tx_tdata,
    output logic              tx_tvalid,
    input  logic              tx_tready,
    output logic              tx_tlast,
    output logic [ID_W-1:0]   tx_tid,
    output logic [DEST_W-1:0] tx_tdest,
    output logic [USER_W-1:0] tx_tuser,
    output logic              irq
);
    localparam int CW = $clog2(DEPTH + 1);

    logic          wr_en, rd_en;
    logic [AW-1:0] wr_addr, rd_addr;
    logic [DW-1:0] wr_data, rd_data;

    logic [IRQ_N-1:0] irq_stat, irq_en, irq_set, irq_clr;
    side_t            tx_side_q, rx_side_q, rx_in_side, tx_out_side;
    logic             tx_flush, rx_flush, all_flush;
    logic             rx_pop, len_pop, tx_push, tx_launch;
    logic [CW-1:0]    rx_occ, tx_vac;
    logic [DW-1:0]    rx_head;
    rx_desc_t         rx_desc;
    logic             rx_desc_ok, rx_done, rx_under, tx_done, tx_over;

    sfb_axil #(.AW(AW), .DW(DW)) u_axil (
        .clk(clk), .rst(rst),
        .awaddr(s_axil_awaddr), .awvalid(s_axil_awvalid), .awready(s_axil_awready),
        .wdata(s_axil_wdata), .wvalid(s_axil_wvalid), .wready(s_axil_wready),
        .bresp(s_axil_bresp), .bvalid(s_axil_bvalid), .bready(s_axil_bready),
        .araddr(s_axil_araddr), .arvalid(s_axil_arvalid), .arready(s_axil_arready),
        .rdata(s_axil_rdata), .rresp(s_axil_rresp), .rvalid(s_axil_rvalid),
        .rready(s_axil_rready),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    // register strobes
    assign all_flush = wr_en && wr_addr == REG_RESET && wr_data[RST_ALL];
    assign tx_flush  = wr_en && wr_addr == REG_RESET && (wr_data[RST_TX] || wr_data[RST_ALL]);
    assign rx_flush  = wr_en && wr_addr == REG_RESET && (wr_data[RST_RX] || wr_data[RST_ALL]);
    assign tx_push   = wr_en && wr_addr == REG_TX_DATA;
    assign tx_launch = wr_en && wr_addr == REG_TX_LEN;
    assign rx_pop    = rd_en && rd_addr == REG_RX_DATA;
    assign len_pop   = rd_en && rd_addr == REG_RX_LEN;

    assign rx_in_side.id   = rx_tid;
    assign rx_in_side.dest = rx_tdest;
    assign rx_in_side.user = rx_tuser;
    assign tx_tid   = tx_out_side.id;
    assign tx_tdest = tx_out_side.dest;
    assign tx_tuser = tx_out_side.user;

    sfb_rx_path #(.DW(DW), .DEPTH(DEPTH), .NDESC(NDESC), .CW(CW)) u_rx (
        .clk(clk), .rst(rst), .flush(rx_flush),
        .s_tdata(rx_tdata), .s_tvalid(rx_tvalid), .s_tlast(rx_tlast),
        .s_side(rx_in_side), .s_tready(rx_tready),
        .pop_data(rx_pop), .pop_desc(len_pop),
        .head_data(rx_head), .occ(rx_occ),
        .head_desc(rx_desc), .desc_avail(rx_desc_ok),
        .done_evt(rx_done), .under_evt(rx_under)
    );

    sfb_tx_path #(.DW(DW), .DEPTH(DEPTH), .CW(CW)) u_tx (
        .clk(clk), .rst(rst), .flush(tx_flush),
        .push(tx_push), .wdata(wr_data),
        .launch(tx_launch), .launch_bytes(wr_data[LEN_W-1:0]),
        .launch_side(tx_side_q), .vacancy(tx_vac),
        .m_tdata(tx_tdata), .m_tvalid(tx_tvalid), .m_tready(tx_tready),
        .m_tlast(tx_tlast), .m_side(tx_out_side),
        .done_evt(tx_done), .over_evt(tx_over)
    );

    // interrupt events and write-one-to-clear
    always_comb begin
        irq_set = '0;
        irq_set[IRQ_RX_DONE]  = rx_done;
        irq_set[IRQ_TX_DONE]  = tx_done;
        irq_set[IRQ_RX_UNDER] = rx_under;
        irq_set[IRQ_TX_OVER]  = tx_over;
        irq_clr = (wr_en && wr_addr == REG_IRQ_STAT) ? wr_data[IRQ_N-1:0] : '0;
    end

    always_ff @(posedge clk) begin
        if (rst || all_flush) begin
            irq_stat  <= '0;
            irq_en    <= '0;
            tx_side_q <= '0;
            rx_side_q <= '0;
        end else begin
            irq_stat <= (irq_stat & ~irq_clr) | irq_set;
            if (wr_en && wr_addr == REG_IRQ_EN)  irq_en    <= wr_data[IRQ_N-1:0];
            if (wr_en && wr_addr == REG_TX_SIDE) tx_side_q <= wr_data[SIDE_W-1:0];
            if (len_pop && rx_desc_ok)           rx_side_q <= rx_desc.side;
        end
    end

    assign irq = |(irq_stat & irq_en);

    always_comb begin
        case (rd_addr)
            REG_IRQ_STAT: rd_data = DW'(irq_stat);
            REG_IRQ_EN:   rd_data = DW'(irq_en);
            REG_TX_VAC:   rd_data = DW'(tx_vac);
            REG_RX_OCC:   rd_data = DW'(rx_occ);
            REG_RX_DATA:  rd_data = (rx_occ == '0) ? '0 : rx_head;
            REG_RX_LEN:   rd_data = rx_desc_ok ? DW'(rx_desc.bytes) : '0;
            REG_TX_SIDE:  rd_data = DW'(tx_side_q);
            REG_RX_SIDE:  rd_data = DW'(rx_side_q);
            default:      rd_data = '0;
        endcase
    end

    // R9: writing all ones with no new event empties the status
    assert_w1c_all_R9: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == REG_IRQ_STAT && (&wr_data[IRQ_N-1:0]) && irq_set == '0)
        |=> (irq_stat == '0));

    // R11: the whole-block reset clears status and enables
    assert_full_reset_R11: assert property (@(posedge clk) disable iff (rst)
        all_flush |=> (irq_stat == '0 && irq_en == '0 && !irq));

    // R10: a raised line always has an enabled cause
    assert_irq_cause_R10: assert property (@(posedge clk) disable iff (rst)
        irq |-> (irq_en != '0));

endmodule

// File: tb/sfb_bridge_tb.sv
module sfb_bridge_tb_top;
    import sfb_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic [7:0]  awaddr = '0, araddr = '0;
    logic        awvalid = 0, wvalid = 0, arvalid = 0;
    logic        bready = 1, rready = 1;
    logic [31:0] wdata = '0;
    logic        awready, wready, bvalid, arready, rvalid;
    logic [1:0]  bresp, rresp;
    logic [31:0] rdata;
    logic [31:0] rx_tdata = '0;
    logic        rx_tvalid = 0, rx_tlast = 0, rx_tready;
    logic [3:0]  rx_tid = '0, rx_tdest = '0;
    logic [7:0]  rx_tuser = '0;
    logic [31:0] tx_tdata;
    logic        tx_tvalid, tx_tlast, irq;
    logic        tx_tready = 0;
    logic [3:0]  tx_tid, tx_tdest;
    logic [7:0]  tx_tuser;

    sfb_bridge dut_i (
        .clk(clk), .rst(rst),
        .s_axil_awaddr(awaddr), .s_axil_awvalid(awvalid), .s_axil_awready(awready),
        .s_axil_wdata(wdata), .s_axil_wvalid(wvalid), .s_axil_wready(wready),
        .s_axil_bresp(bresp), .s_axil_bvalid(bvalid), .s_axil_bready(bready),
        .s_axil_araddr(araddr), .s_axil_arvalid(arvalid), .s_axil_arready(arready),
        .s_axil_rdata(rdata), .s_axil_rresp(rresp), .s_axil_rvalid(rvalid),
        .s_axil_rready(rready),
        .rx_tdata(rx_tdata), .rx_tvalid(rx_tvalid), .rx_tready(rx_tready),
        .rx_tlast(rx_tlast), .rx_tid(rx_tid), .rx_tdest(rx_tdest), .rx_tuser(rx_tuser),
        .tx_tdata(tx_tdata), .tx_tvalid(tx_tvalid), .tx_tready(tx_tready),
        .tx_tlast(tx_tlast), .tx_tid(tx_tid), .tx_tdest(tx_tdest), .tx_tuser(tx_tuser),
        .irq(irq)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    typedef struct { logic [31:0] d; logic l; logic [15:0] s; } beat_t;
    beat_t exp_q[$];

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        awaddr = a; wdata = d; awvalid = 1; wvalid = 1;
        while (1) begin #1; if (awready) break; @(negedge clk); end
        @(posedge clk);
        @(negedge clk);
        awvalid = 0; wvalid = 0;
        chk("R1", "write response", {29'd0, bvalid, bresp}, 32'h4);
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        araddr = a; arvalid = 1;
        while (1) begin #1; if (arready) break; @(negedge clk); end
        @(posedge clk);
        @(negedge clk);
        arvalid = 0;
        chk("R1", "read response", {29'd0, rvalid, rresp}, 32'h4);
        d = rdata;
    endtask

    task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        chk(req, $sformatf("reg 0x%0h", a), v, exp);
    endtask

    task automatic rx_send(input logic [31:0] d, input logic last, input logic [15:0] s);
        @(negedge clk);
        rx_tdata = d; rx_tlast = last; rx_tvalid = 1;
        {rx_tuser, rx_tdest, rx_tid} = s;
        while (1) begin #1; if (rx_tready) break; @(negedge clk); end
        @(posedge clk);
        @(negedge clk);
        rx_tvalid = 0; rx_tlast = 0;
    endtask

    task automatic tx_push(input logic [31:0] d, input logic last, input logic [15:0] s);
        beat_t b;
        b.d = d; b.l = last; b.s = s;
        exp_q.push_back(b);
        wr(REG_TX_DATA, d);
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    // sink backpressure pattern
    initial begin
        int cyc = 0;
        forever begin
            @(negedge clk);
            cyc++;
            tx_tready = (cyc % 3) != 0;
        end
    end

    // scoreboard monitor: compare beats that will complete at the next edge
    initial begin
        logic        stalled = 0;
        logic [31:0] held_d  = '0;
        logic        held_l  = 0;
        forever begin
            @(negedge clk);
            #2;
            if (stalled) begin
                chk("R12", "valid held", {31'd0, tx_tvalid}, 32'd1);
                chk("R12", "data held", tx_tdata, held_d);
                chk("R12", "last held", {31'd0, tx_tlast}, {31'd0, held_l});
            end
            stalled = tx_tvalid && !tx_tready;
            held_d  = tx_tdata;
            held_l  = tx_tlast;
            if (tx_tvalid && tx_tready) begin
                if (exp_q.size() == 0) begin
                    chk("R7", "unexpected beat", tx_tdata, 32'hDEAD_BEEF);
                end else begin
                    beat_t b;
                    b = exp_q.pop_front();
                    chk("R7", "tx data", tx_tdata, b.d);
                    chk("R7", "tx last", {31'd0, tx_tlast}, {31'd0, b.l});
                    chk("R8", "tx side", {16'd0, tx_tuser, tx_tdest, tx_tid}, {16'd0, b.s});
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (5) @(negedge clk);
        rst = 0;
        @(negedge clk);

        // R2 reset state
        chk("R2", "irq", {31'd0, irq}, 0);
        chk("R2", "tx_tvalid", {31'd0, tx_tvalid}, 0);
        chk("R2", "rx_tready", {31'd0, rx_tready}, 1);
        rd_chk("R2", REG_IRQ_STAT, 0);
        rd_chk("R2", REG_TX_VAC, 512);
        rd_chk("R2", REG_RX_OCC, 0);

        // R4 length appears only after TLAST
        rx_send(32'hA0, 0, 16'h7A53);
        rx_send(32'hA1, 0, 16'h7A53);
        rd_chk("R3", REG_RX_OCC, 2);
        rd_chk("R4", REG_RX_LEN, 0);
        rx_send(32'hA2, 1, 16'h7A53);
        rd_chk("R4", REG_RX_LEN, 12);
        rd_chk("R8", REG_RX_SIDE, 32'h7A53);
        rd_chk("R9", REG_IRQ_STAT, 32'h1);
        rd_chk("R5", REG_RX_DATA, 32'hA0);
        rd_chk("R5", REG_RX_DATA, 32'hA1);
        rd_chk("R5", REG_RX_DATA, 32'hA2);
        rd_chk("R3", REG_RX_OCC, 0);

        // R5 underrun
        rd_chk("R5", REG_RX_DATA, 0);
        rd_chk("R5", REG_RX_OCC, 0);
        rd_chk("R5", REG_IRQ_STAT, 32'h5);

        // R10 enable gating, R9 clear
        chk("R10", "irq masked", {31'd0, irq}, 0);
        wr(REG_IRQ_EN, 32'h4);
        chk("R10", "irq enabled", {31'd0, irq}, 1);
        wr(REG_IRQ_STAT, 32'hFFFF_FFFF);
        chk("R9", "irq after clear", {31'd0, irq}, 0);
        rd_chk("R9", REG_IRQ_STAT, 0);

        // R4 two queued packets, consumed in order
        rx_send(32'hB0, 1, 16'h1111);
        rx_send(32'hC0, 0, 16'h2222);
        rx_send(32'hC1, 1, 16'h2222);
        rd_chk("R4", REG_RX_LEN, 4);
        rd_chk("R8", REG_RX_SIDE, 32'h1111);
        rd_chk("R5", REG_RX_DATA, 32'hB0);
        rd_chk("R4", REG_RX_LEN, 8);
        rd_chk("R8", REG_RX_SIDE, 32'h2222);
        rd_chk("R5", REG_RX_DATA, 32'hC0);
        rd_chk("R5", REG_RX_DATA, 32'hC1);
        rd_chk("R4", REG_RX_LEN, 0);
        wr(REG_IRQ_STAT, 32'hF);

        // R6 R7 R8 transmit packet
        wr(REG_TX_SIDE, 32'hC429);
        tx_push(32'h1000, 0, 16'hC429);
        tx_push(32'h1001, 0, 16'hC429);
        tx_push(32'h1002, 0, 16'hC429);
        tx_push(32'h1003, 1, 16'hC429);
        rd_chk("R6", REG_TX_VAC, 508);
        chk("R7", "no send before length", {31'd0, tx_tvalid}, 0);
        wr(REG_TX_LEN, 16);
        drain();
        rd_chk("R9", REG_IRQ_STAT, 32'h2);
        rd_chk("R6", REG_TX_VAC, 512);

        // R7 byte length rounds up to words
        wr(REG_TX_SIDE, 32'h0518);
        tx_push(32'h2000, 0, 16'h0518);
        tx_push(32'h2001, 1, 16'h0518);
        wr(REG_TX_LEN, 6);
        drain();

        // R7 zero length launches nothing
        wr(REG_TX_DATA, 32'h3000);
        wr(REG_TX_LEN, 0);
        repeat (10) @(negedge clk);
        chk("R7", "zero length idle", {31'd0, tx_tvalid}, 0);
        rd_chk("R7", REG_TX_VAC, 511);
        begin
            beat_t b;
            b.d = 32'h3000; b.l = 1; b.s = 16'h0518;
            exp_q.push_back(b);
        end
        wr(REG_TX_LEN, 4);
        drain();
        wr(REG_IRQ_STAT, 32'hF);

        // R6 overrun, R11 transmit flush
        for (int i = 0; i < 512; i++) wr(REG_TX_DATA, 32'h4000 + i);
        rd_chk("R6", REG_TX_VAC, 0);
        wr(REG_TX_DATA, 32'h5555);
        rd_chk("R6", REG_TX_VAC, 0);
        rd_chk("R6", REG_IRQ_STAT, 32'h8);
        wr(REG_RESET, 32'h1);
        rd_chk("R11", REG_TX_VAC, 512);
        chk("R11", "tx idle after flush", {31'd0, tx_tvalid}, 0);

        // R3 receive full, R11 receive flush
        for (int i = 0; i < 512; i++) rx_send(32'h6000 + i, i == 511, 16'h0);
        rd_chk("R3", REG_RX_OCC, 512);
        @(negedge clk);
        rx_tvalid = 1; rx_tdata = 32'h7777;
        #1;
        chk("R3", "tready when full", {31'd0, rx_tready}, 0);
        rx_tvalid = 0;
        wr(REG_RESET, 32'h2);
        rd_chk("R11", REG_RX_OCC, 0);
        rd_chk("R11", REG_RX_LEN, 0);
        chk("R11", "tready after flush", {31'd0, rx_tready}, 1);

        // R11 whole-block reset
        wr(REG_IRQ_EN, 32'hF);
        wr(REG_TX_SIDE, 32'hABCD);
        rd(REG_RX_DATA, v);
        chk("R10", "irq before reset", {31'd0, irq}, 1);
        wr(REG_RESET, 32'h4);
        chk("R11", "irq after reset", {31'd0, irq}, 0);
        rd_chk("R11", REG_IRQ_STAT, 0);
        rd_chk("R11", REG_IRQ_EN, 0);
        rd_chk("R11", REG_TX_SIDE, 0);
        rd_chk("R11", REG_TX_VAC, 512);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule